// File: doc/BRIEF.md
# Reset-Latched Boot Mode Sequencer

This block reads four boot-configuration pins while the chip is held in reset and keeps that value for the rest of the power cycle. From the latched value it decides whether the part runs in full memory mode or host mode and how the acknowledge pin of the host port is driven. It also picks one of three ways to start the core. In the first, a byte-DMA engine copies the first 32 program words out of a byte-wide external memory into internal program memory. In the second, the block waits for a host to write internal program address 0. In the third, the core starts at once from external address 0.

The byte-DMA engine issues one byte read per cycle. The external memory returns each byte one cycle after the read strobe. Every three bytes are packed into one 24-bit program word, most significant byte first. The same engine can be started later by a kick input. In no-boot mode that kick never gates the core. The core-release output is a single level. Reset clears it, and it rises once, in the cycle after the release condition of the latched mode is met.

Top module: `boot_seq_top`

## Requirements
- R1: The mode pins {D,C,B,A} = mode_pins[3:0] are captured only on clock edges where rst_n is low. Changes on mode_pins after reset has deasserted alter no output of the block.
- R2: With {C,B,A} = 000, the engine loads the boot image and core_run stays low until all 32 words have been written. host_mode is 0 whatever the value of D.
- R3: With {C,B,A} = 010, core_run rises on the first clock edge after reset deasserts, no boot read is issued, host_mode is 0, and D has no effect.
- R4: With {C,B,A} = 100, the boot is a byte-DMA boot as in R2, but host_mode is 1.
- R5: With {C,B,A} = 101, host_mode is 1 and no byte read is issued. A host write (host_pm_we high) to any nonzero host_pm_addr leaves core_run low. A host write to address 0 makes core_run rise on the next cycle.
- R6: ack_open_drain equals host_mode AND D. The value 1 means the acknowledge output only pulls low or floats. The value 0 means it is driven actively.
- R7: Boot byte reads go to byte_addr 0, 1, 2, … in consecutive order. Program word w is written at pm_addr w and equals {byte(3w), byte(3w+1), byte(3w+2)}, with the first byte in bits 23:16. Read data is taken one cycle after the byte_rd strobe.
- R8: A load performs exactly 96 byte reads and 32 program writes. byte_rd and pm_we stay low after the load has finished.
- R9: Any {C,B,A} other than 000, 010, 100 and 101 behaves as no-boot (R3) with host_mode 0. illegal_mode goes to 1 and stays at 1 until reset. For the legal codes illegal_mode is 0.
- R10: Reset drives core_run, byte_rd and pm_we low. In a DMA boot, core_run rises in the cycle after the pm_we pulse that writes address 31. Once high, core_run stays high until reset.
- R11: A pulse on dma_kick while the engine is idle starts a new 32-word load. In no-boot mode this load does not affect core_run. A pulse on dma_kick during a load is ignored, so the load still ends after 32 words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low; mode pins are sampled while low |
| mode_pins | input | 4 | Boot configuration pins {D,C,B,A} |
| dma_kick | input | 1 | Software request to start a 32-word byte-DMA load |
| byte_addr | output | 16 | External byte memory address |
| byte_rd | output | 1 | External byte memory read strobe |
| byte_data | input | 8 | Read data, valid one cycle after byte_rd |
| pm_we | output | 1 | Internal program memory write strobe from the engine |
| pm_addr | output | 14 | Program memory word address |
| pm_wdata | output | 24 | Packed program word |
| host_pm_we | input | 1 | Host write to internal program memory, observed only |
| host_pm_addr | input | 14 | Address of the observed host write |
| core_run | output | 1 | Core release level |
| host_mode | output | 1 | 1 = host mode, 0 = full memory mode |
| ack_open_drain | output | 1 | 1 = acknowledge pin open-drain, 0 = actively driven |
| illegal_mode | output | 1 | Sticky flag for an unlisted mode code |

## Verification
The decoded mode outputs are valid from the first falling edge after reset releases. core_run is due one cycle after its condition, which is the first edge out of reset in no-boot mode, the observed write to address 31 in a DMA boot, and the host write to address 0 in a host boot. A packed word appears on pm_we two cycles after the read strobe of its third byte. The bench samples every output on the falling edge, keyed to the event it saw at the falling edge before. For example, it checks core_run low on the edge where the last write is visible and high on the next edge, so each check lands on the exact cycle without counting absolute latencies.

// File: rtl/boot_seq_pkg.sv
package boot_seq_pkg;

  typedef enum logic [1:0] {
    BM_NONE = 2'd0,
    BM_BDMA = 2'd1,
    BM_HOST = 2'd2
  } boot_method_e;

  typedef struct packed {
    boot_method_e method;
    logic         host_mode;
    logic         ack_od;
    logic         illegal;
  } boot_cfg_t;

  // pins = {D, C, B, A}
  function automatic boot_cfg_t decode_pins(input logic [3:0] pins);
    boot_cfg_t c;
    c.method    = BM_NONE;
    c.host_mode = 1'b0;
    c.illegal   = 1'b0;
    case (pins[2:0])
      3'b000: c.method = BM_BDMA;
      3'b010: c.method = BM_NONE;
      3'b100: begin c.method = BM_BDMA; c.host_mode = 1'b1; end
      3'b101: begin c.method = BM_HOST; c.host_mode = 1'b1; end
      default: c.illegal = 1'b1;
    endcase
    c.ack_od = c.host_mode & pins[3];
    return c;
  endfunction

  function automatic int bytes_total(input int words, input int bpw);
    return words * bpw;
  endfunction

endpackage

// File: rtl/boot_pin_latch.sv
module boot_pin_latch
  import boot_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] mode_pins,
  output boot_cfg_t  cfg,
  output logic       illegal_flag
);

  logic [3:0] mode_q;
  logic       ill_q;

  // pins are only looked at while reset is held
  always_ff @(posedge clk) begin
    if (!rst_n) mode_q <= mode_pins;
  end

  assign cfg = decode_pins(mode_q);

  always_ff @(posedge clk) begin
    if (!rst_n)           ill_q <= 1'b0;
    else if (cfg.illegal) ill_q <= 1'b1;
  end

  assign illegal_flag = ill_q;

  // R1: latched pins never move once reset is gone
  a_r1_pins_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(mode_q));

  // R9: flag is sticky
  a_r9_illegal_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ill_q |=> ill_q);

endmodule

// File: rtl/boot_byte_dma.sv
module boot_byte_dma
  import boot_seq_pkg::*;
#(
  parameter int WORDS  = 32,
  parameter int BPW    = 3,
  parameter int BYTE_W = 8,
  parameter int BA_W   = 16,
  parameter int PA_W   = 14
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  output logic [BA_W-1:0]       byte_addr,
  output logic                  byte_rd,
  input  logic [BYTE_W-1:0]     byte_data,
  output logic                  pm_we,
  output logic [PA_W-1:0]       pm_addr,
  output logic [BYTE_W*BPW-1:0] pm_wdata,
  output logic                  busy,
  output logic                  last_wr
);

  localparam int TOTAL  = bytes_total(WORDS, BPW);
  localparam int WORD_W = BYTE_W * BPW;
  localparam int IC_W   = $clog2(TOTAL + 1);
  localparam int POS_W  = $clog2(BPW + 1);
  localparam int WC_W   = $clog2(WORDS + 1);

  logic [IC_W-1:0]   issue_cnt;
  logic [POS_W-1:0]  pos_q;
  logic [WC_W-1:0]   word_q;
  logic [WORD_W-1:0] acc_q;
  logic [WORD_W-1:0] acc_next;
  logic [WORD_W-1:0] wdata_q;
  logic [PA_W-1:0]   addr_q;
  logic              rd_q;
  logic              busy_q;
  logic              we_q;

  // named internal events
  logic issue_en;
  logic word_done;
  logic final_word;

  assign issue_en   = busy_q && (issue_cnt != IC_W'(TOTAL));
  assign acc_next   = {acc_q[WORD_W-BYTE_W-1:0], byte_data};
  assign word_done  = rd_q && (pos_q == POS_W'(BPW - 1));
  assign final_word = word_done && (word_q == WC_W'(WORDS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      issue_cnt <= '0;
      pos_q     <= '0;
      word_q    <= '0;
      acc_q     <= '0;
      wdata_q   <= '0;
      addr_q    <= '0;
      rd_q      <= 1'b0;
      busy_q    <= 1'b0;
      we_q      <= 1'b0;
    end else begin
      we_q <= 1'b0;
      if (start && !busy_q) begin
        busy_q    <= 1'b1;
        issue_cnt <= '0;
        pos_q     <= '0;
        word_q    <= '0;
        rd_q      <= 1'b0;
      end else begin
        rd_q <= issue_en;
        if (issue_en) issue_cnt <= issue_cnt + 1'b1;
        if (rd_q) begin
          acc_q <= acc_next;
          if (word_done) begin
            pos_q   <= '0;
            we_q    <= 1'b1;
            wdata_q <= acc_next;
            addr_q  <= PA_W'(word_q);
            word_q  <= word_q + 1'b1;
            if (final_word) busy_q <= 1'b0;
          end else begin
            pos_q <= pos_q + 1'b1;
          end
        end
      end
    end
  end

  assign byte_addr = BA_W'(issue_cnt);
  assign byte_rd   = issue_en;
  assign pm_we     = we_q;
  assign pm_addr   = addr_q;
  assign pm_wdata  = wdata_q;
  assign busy      = busy_q;
  assign last_wr   = we_q && (addr_q == PA_W'(WORDS - 1));

  // R7: consecutive reads walk the byte space by one
  a_r7_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    byte_rd && $past(byte_rd) |-> byte_addr == $past(byte_addr) + 1'b1);

  // R8: a program write only follows a cycle of an active load
  a_r8_write_in_load: assert property (@(posedge clk) disable iff (!rst_n)
    pm_we |-> $past(busy_q));

  // R7: written addresses stay inside the boot window
  a_r7_pm_range: assert property (@(posedge clk) disable iff (!rst_n)
    pm_we |-> pm_addr < PA_W'(WORDS));

  // R11: a kick during a load does not rewind it
  a_r11_kick_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && start && issue_en |=> issue_cnt != '0);

endmodule

// File: rtl/boot_release_ctl.sv
module boot_release_ctl
  import boot_seq_pkg::*;
#(
  parameter int PA_W = 14
) (
  input  logic            clk,
  input  logic            rst_n,
  input  boot_method_e    method,
  input  logic            dma_last,
  input  logic            host_pm_we,
  input  logic [PA_W-1:0] host_pm_addr,
  output logic            boot_go,
  output logic            core_run
);

  logic armed_q;
  logic run_q;
  logic host_hit;
  logic release_cond;

  assign host_hit = host_pm_we && (host_pm_addr == '0);

  always_comb begin
    case (method)
      BM_BDMA: release_cond = dma_last;
      BM_HOST: release_cond = host_hit;
      default: release_cond = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      run_q   <= 1'b0;
    end else begin
      armed_q <= 1'b1;
      if (release_cond) run_q <= 1'b1;
    end
  end

  // one-shot boot load request in the first cycle out of reset
  assign boot_go  = !armed_q && (method == BM_BDMA);
  assign core_run = run_q;

  // R10: release is a one-way level
  a_r10_run_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |=> run_q);

  // R5: host boot releases only after a write to address 0
  a_r5_host_release: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_q) && (method == BM_HOST) |-> $past(host_hit));

  // R2: byte-DMA boot releases only after the last word
  a_r2_dma_release: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_q) && (method == BM_BDMA) |-> $past(dma_last));

  // R3: no-boot runs from the first cycle after reset
  a_r3_immediate: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q && (method == BM_NONE) |-> run_q);

endmodule

// File: rtl/boot_seq_top.sv
module boot_seq_top
  import boot_seq_pkg::*;
#(
  parameter int WORDS  = 32,
  parameter int BPW    = 3,
  parameter int BYTE_W = 8,
  parameter int BA_W   = 16,
  parameter int PA_W   = 14
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [3:0]            mode_pins,
  input  logic                  dma_kick,
  output logic [BA_W-1:0]       byte_addr,
  output logic                  byte_rd,
  input  logic [BYTE_W-1:0]     byte_data,
  output logic                  pm_we,
  output logic [PA_W-1:0]       pm_addr,
  output logic [BYTE_W*BPW-1:0] pm_wdata,
  input  logic                  host_pm_we,
  input  logic [PA_W-1:0]       host_pm_addr,
  output logic                  core_run,
  output logic                  host_mode,
  output logic                  ack_open_drain,
  output logic                  illegal_mode
);

  boot_cfg_t cfg;
  logic      dma_busy;
  logic      dma_last;
  logic      boot_go;
  logic      dma_start;

  boot_pin_latch u_latch (
    .clk          (clk),
    .rst_n        (rst_n),
    .mode_pins    (mode_pins),
    .cfg          (cfg),
    .illegal_flag (illegal_mode)
  );

  assign dma_start = boot_go | dma_kick;

  boot_byte_dma #(
    .WORDS (WORDS), .BPW (BPW), .BYTE_W (BYTE_W), .BA_W (BA_W), .PA_W (PA_W)
  ) u_dma (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (dma_start),
    .byte_addr (byte_addr),
    .byte_rd   (byte_rd),
    .byte_data (byte_data),
    .pm_we     (pm_we),
    .pm_addr   (pm_addr),
    .pm_wdata  (pm_wdata),
    .busy      (dma_busy),
    .last_wr   (dma_last)
  );

  boot_release_ctl #(.PA_W (PA_W)) u_rel (
    .clk          (clk),
    .rst_n        (rst_n),
    .method       (cfg.method),
    .dma_last     (dma_last),
    .host_pm_we   (host_pm_we),
    .host_pm_addr (host_pm_addr),
    .boot_go      (boot_go),
    .core_run     (core_run)
  );

  assign host_mode      = cfg.host_mode;
  assign ack_open_drain = cfg.ack_od;

  // R5: host boot never touches the byte memory on its own
  a_r5_host_no_reads: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.method == BM_HOST) && !dma_busy && !dma_kick |=> !byte_rd);

endmodule

// File: tb/sim_boot_seq_top.sv
module sim_boot_seq_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  mode_pins = 4'b0000;
  logic        dma_kick = 1'b0;
  logic [15:0] byte_addr;
  logic        byte_rd;
  logic [7:0]  byte_data = 8'h00;
  logic        pm_we;
  logic [13:0] pm_addr;
  logic [23:0] pm_wdata;
  logic        host_pm_we = 1'b0;
  logic [13:0] host_pm_addr = '0;
  logic        core_run;
  logic        host_mode;
  logic        ack_open_drain;
  logic        illegal_mode;

  int total = 0;
  int bad   = 0;

  always #10 clk = ~clk;  // 50 MHz

  boot_seq_top u0 (
    .clk (clk), .rst_n (rst_n), .mode_pins (mode_pins), .dma_kick (dma_kick),
    .byte_addr (byte_addr), .byte_rd (byte_rd), .byte_data (byte_data),
    .pm_we (pm_we), .pm_addr (pm_addr), .pm_wdata (pm_wdata),
    .host_pm_we (host_pm_we), .host_pm_addr (host_pm_addr),
    .core_run (core_run), .host_mode (host_mode),
    .ack_open_drain (ack_open_drain), .illegal_mode (illegal_mode)
  );

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 37 + 11) & 255);
  endfunction

  function automatic logic [23:0] exp_word(input int w);
    return {pat(3 * w), pat(3 * w + 1), pat(3 * w + 2)};
  endfunction

  // external byte memory, one-cycle read latency
  always_ff @(posedge clk) begin
    if (byte_rd) byte_data <= pat(int'(byte_addr));
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // {mode[3:0], kind[1:0] (0 none,1 dma,2 host), host, od, illegal}
  localparam logic [8:0] VEC [11] = '{
    {4'b0000, 2'd1, 1'b0, 1'b0, 1'b0},
    {4'b1000, 2'd1, 1'b0, 1'b0, 1'b0},
    {4'b0010, 2'd0, 1'b0, 1'b0, 1'b0},
    {4'b1010, 2'd0, 1'b0, 1'b0, 1'b0},
    {4'b0100, 2'd1, 1'b1, 1'b0, 1'b0},
    {4'b1100, 2'd1, 1'b1, 1'b1, 1'b0},
    {4'b0101, 2'd2, 1'b1, 1'b0, 1'b0},
    {4'b1101, 2'd2, 1'b1, 1'b1, 1'b0},
    {4'b0011, 2'd0, 1'b0, 1'b0, 1'b1},
    {4'b1110, 2'd0, 1'b0, 1'b0, 1'b1},
    {4'b0111, 2'd0, 1'b0, 1'b0, 1'b1}
  };

  task automatic reset_with(input logic [3:0] m);
    @(negedge clk);
    rst_n = 1'b0;
    mode_pins = m;
    host_pm_we = 1'b0;
    dma_kick = 1'b0;
    repeat (3) @(negedge clk);
    chk(!core_run && !pm_we && !byte_rd, "R10 reset state",
        {core_run, pm_we, byte_rd}, 0);
    rst_n = 1'b1;
  endtask

  // watches one 32-word load; run_high: core_run must stay high throughout
  task automatic watch_load(input bit run_high, input bit kick_mid);
    int nw = 0;
    int nr = 0;
    int addr_bad = 0;
    int data_bad = 0;
    int run_bad = 0;
    bit last_seen = 0;
    bit kicked = 0;
    for (int cyc = 0; cyc < 400; cyc++) begin
      @(negedge clk);
      dma_kick = 1'b0;
      if (last_seen && !run_high) begin
        chk(core_run == 1'b1, "R10 release one cycle after last write", core_run, 1);
        break;
      end
      if (core_run != run_high) run_bad++;
      if (byte_rd) begin
        if (int'(byte_addr) != nr) addr_bad++;
        nr++;
      end
      if (pm_we) begin
        if (int'(pm_addr) != nw || pm_wdata != exp_word(nw)) begin
          data_bad++;
          $display("  word %0d at %0d data %h want %h", nw, pm_addr, pm_wdata, exp_word(nw));
        end
        if (pm_addr == 14'd31) last_seen = 1;
        nw++;
      end
      if (kick_mid && !kicked && nw == 5) begin
        dma_kick = 1'b1;
        kicked = 1;
      end
      if (run_high && last_seen) break;
    end
    chk(run_bad == 0, run_high ? "R11 core_run unaffected by load" : "R2 core held until 32 words",
        run_bad, 0);
    chk(addr_bad == 0, "R7 byte address sequence", addr_bad, 0);
    chk(data_bad == 0, "R7 word packing and order", data_bad, 0);
    chk(nr == 96, "R8 byte read count", nr, 96);
    chk(nw == 32, "R8 word write count", nw, 32);
    begin
      int quiet_bad = 0;
      repeat (8) begin
        @(negedge clk);
        if (byte_rd || pm_we) quiet_bad++;
      end
      chk(quiet_bad == 0, "R8 idle after load", quiet_bad, 0);
    end
  endtask

  task automatic host_boot(input logic exp_host);
    int early = 0;
    mode_pins = 4'b0010;  // would be no-boot if still sampled (R1)
    repeat (4) begin
      @(negedge clk);
      if (core_run || byte_rd) early++;
    end
    chk(early == 0, "R1 R5 pins after reset ignored, core held", early, 0);
    chk(host_mode == exp_host, "R1 host_mode kept after pin change", host_mode, exp_host);
    host_pm_addr = 14'd7;
    host_pm_we = 1'b1;
    @(negedge clk);
    host_pm_we = 1'b0;
    chk(core_run == 1'b0, "R5 write to nonzero address", core_run, 0);
    @(negedge clk);
    chk(core_run == 1'b0, "R5 still held", core_run, 0);
    host_pm_addr = 14'd0;
    host_pm_we = 1'b1;
    @(negedge clk);
    host_pm_we = 1'b0;
    chk(core_run == 1'b1, "R5 release after write to 0", core_run, 1);
    repeat (3) @(negedge clk);
    chk(core_run == 1'b1, "R10 core_run stays high", core_run, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 11; i++) begin
      logic [3:0] m;
      logic [1:0] kind;
      m    = VEC[i][8:5];
      kind = VEC[i][4:3];
      reset_with(m);
      chk(host_mode == VEC[i][2], "R4 host_mode decode", host_mode, VEC[i][2]);
      chk(ack_open_drain == VEC[i][1], "R6 ack drive style", ack_open_drain, VEC[i][1]);
      case (kind)
        2'd1: watch_load(1'b0, i == 0);
        2'd2: host_boot(VEC[i][2]);
        default: begin
          @(negedge clk);
          chk(core_run == 1'b1 && !byte_rd, "R3 immediate start", core_run, 1);
          chk(illegal_mode == VEC[i][0], "R9 illegal flag", illegal_mode, VEC[i][0]);
          @(negedge clk);
          dma_kick = 1'b1;
          watch_load(1'b1, 1'b0);
          chk(illegal_mode == VEC[i][0], "R9 illegal flag held", illegal_mode, VEC[i][0]);
        end
      endcase
    end
    // R10: reset drops a released core
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(core_run == 1'b0 && illegal_mode == 1'b0, "R10 reset clears release",
        {core_run, illegal_mode}, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule